// File: doc/BRIEF.md
# Per-Field Vertical Timing Generator

This block produces the line-aligned vertical signals of a video timing path: a vertical reference pulse that marks the blanking interval, a separate vertical sync pulse, and the V flag placed into embedded start/end-of-active-video codes. It counts lines from a per-line strobe. It restarts the count at the first line of every field, which is signalled either by a frame-start strobe or by a change of the field identifier. Interlaced formats alternate the field identifier. Progressive formats hold it at field 1 and pulse the frame-start strobe once per frame.

A byte-wide write port loads four pulse settings: reference and sync, each for field 1 and field 2. Each setting is an 11-bit start line and an 8-bit width in lines. Written values sit in a staging bank and are copied into the active bank only at a field boundary, so a pulse is never reshaped part-way through a field. A zero start or a zero width keeps the corresponding output low for that field.

Top module: `vert_timing_gen`

## Requirements
- R1: Setting register address = pulse*6 + field*3 + part, with pulse 0 = reference and 1 = sync, field 0 = field 1 and 1 = field 2. Part 0 holds start[7:0], part 1 holds start[10:8] in data bits 2:0 with bits 7:3 ignored, and part 2 holds the width. Addresses 12 to 15 are ignored.
- R2: On a line strobe, the line count becomes 1 when frame_start is high or when field_id differs from the field of the previous line. Otherwise it increments by one and holds at 2047.
- R3: vref is high for a line numbered L when start <= L < start + width, using the active field's reference setting. The sum is formed at 12 bits.
- R4: vs follows the same window rule using the active field's sync setting.
- R5: v_flag equals vref on every line.
- R6: In either field, a start of zero or a width of zero keeps that field's output low.
- R7: Settings written during a field take effect at the next field boundary (R2). The current field keeps its old settings.
- R8: Outputs update in the cycle after a line strobe and hold their value until the cycle after the next line strobe.
- R9: After reset all settings are zero and all outputs are low. Reset asserts asynchronously and releases after two clock edges.
- R10: With field_id held at 0 and frame_start pulsed per frame (progressive), every frame uses the field 1 settings and the count restarts at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_strobe | input | 1 | One-cycle pulse at each line start |
| frame_start | input | 1 | Qualifies a line strobe as the first line of a frame |
| field_id | input | 1 | Field of the line being started: 0 = field 1, 1 = field 2 |
| wr_en | input | 1 | Setting write enable |
| wr_addr | input | 4 | Setting register address (R1) |
| wr_data | input | 8 | Setting write data |
| vref | output | 1 | Vertical reference pulse |
| vs | output | 1 | Vertical sync pulse |
| v_flag | output | 1 | V flag for embedded timing codes |

## Verification
Interlaced frames use different, overlapping windows in the two fields, which shows whether the active bank follows field_id and whether the count restarts on a field change without frame_start. Zero starts and zero widths in each field separate the disable rule from the window test. A write in the middle of a field checks the deferred update. A start of 260, set through a high byte with junk in its unused bits, checks the split-byte layout. A window that extends past 2047 lines checks saturation and the 12-bit sum. Progressive frames with only frame_start checks restarts within a single field.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  localparam int LINE_W    = 11;
  localparam int WID_W     = 8;
  localparam int ADDR_W    = 4;
  localparam int NUM_PULSE = 2;
  localparam int NUM_FIELD = 2;
  localparam int NUM_CFG   = NUM_PULSE * NUM_FIELD;
  localparam int PARTS     = 3;

  typedef struct packed {
    logic [LINE_W-1:0] start;
    logic [WID_W-1:0]  width;
  } pulse_cfg_t;
endpackage

// File: rtl/vtg_line_counter.sv
module vtg_line_counter
  import vtg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_strobe,
  input  logic              frame_start,
  input  logic              field_id,
  output logic [LINE_W-1:0] cnt_q,
  output logic [LINE_W-1:0] cnt_d,
  output logic              field_q,
  output logic              field_d,
  output logic              boundary
);
  localparam logic [LINE_W-1:0] CNT_MAX = '1;

  always_comb begin
    boundary = line_strobe && (frame_start || (field_id != field_q));
    cnt_d    = cnt_q;
    field_d  = field_q;
    if (boundary) begin
      cnt_d   = LINE_W'(1);
      field_d = field_id;
    end else if (line_strobe && (cnt_q != CNT_MAX)) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      field_q <= 1'b0;
    end else if (line_strobe) begin
      cnt_q   <= cnt_d;
      field_q <= field_d;
    end
  end
endmodule

// File: rtl/vtg_cfg_bank.sv
module vtg_cfg_bank
  import vtg_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [7:0]               wr_data,
  input  logic                     load,
  output pulse_cfg_t [NUM_CFG-1:0] cfg_q,
  output pulse_cfg_t [NUM_CFG-1:0] cfg_next
);
  localparam int HI_W = LINE_W - 8;

  pulse_cfg_t [NUM_CFG-1:0] stage_q, stage_d;

  always_comb begin
    stage_d = stage_q;
    if (wr_en) begin
      for (int e = 0; e < NUM_CFG; e++) begin
        if (wr_addr == ADDR_W'((e / NUM_FIELD) * NUM_FIELD * PARTS + (e % NUM_FIELD) * PARTS))
          stage_d[e].start[7:0] = wr_data;
        if (wr_addr == ADDR_W'((e / NUM_FIELD) * NUM_FIELD * PARTS + (e % NUM_FIELD) * PARTS + 1))
          stage_d[e].start[LINE_W-1:8] = wr_data[HI_W-1:0];
        if (wr_addr == ADDR_W'((e / NUM_FIELD) * NUM_FIELD * PARTS + (e % NUM_FIELD) * PARTS + 2))
          stage_d[e].width = wr_data[WID_W-1:0];
      end
    end
  end

  assign cfg_next = load ? stage_q : cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      cfg_q   <= '0;
    end else begin
      if (wr_en) stage_q <= stage_d;
      if (load)  cfg_q   <= stage_q;
    end
  end
endmodule

// File: rtl/vtg_window.sv
module vtg_window
  import vtg_pkg::*;
(
  input  logic [LINE_W-1:0] cnt,
  input  pulse_cfg_t        cfg,
  output logic              hit
);
  logic [LINE_W:0] stop;

  always_comb begin
    stop = {1'b0, cfg.start} + {{(LINE_W + 1 - WID_W){1'b0}}, cfg.width};
    hit  = (cfg.start != '0) && (cfg.width != '0) &&
           (cnt >= cfg.start) && ({1'b0, cnt} < stop);
  end
endmodule

// File: rtl/vert_timing_gen.sv
module vert_timing_gen
  import vtg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_strobe,
  input  logic              frame_start,
  input  logic              field_id,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              vref,
  output logic              vs,
  output logic              v_flag
);
  logic [1:0]               rst_pipe;
  logic                     rst_q_n;
  logic [LINE_W-1:0]        cnt_q, cnt_d;
  logic                     field_q, field_d, boundary;
  pulse_cfg_t [NUM_CFG-1:0] cfg_q, cfg_next;
  logic [NUM_PULSE-1:0]     hit;
  logic                     vref_d, vs_d, vflag_d;
  pulse_cfg_t               vref_act, vs_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  vtg_line_counter u_cnt (
    .clk(clk), .rst_n(rst_q_n), .line_strobe(line_strobe),
    .frame_start(frame_start), .field_id(field_id),
    .cnt_q(cnt_q), .cnt_d(cnt_d), .field_q(field_q), .field_d(field_d),
    .boundary(boundary)
  );

  vtg_cfg_bank u_bank (
    .clk(clk), .rst_n(rst_q_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .load(boundary), .cfg_q(cfg_q), .cfg_next(cfg_next)
  );

  for (genvar p = 0; p < NUM_PULSE; p++) begin : g_pulse
    pulse_cfg_t sel_cfg;
    assign sel_cfg = cfg_next[{1'(p), field_d}];
    vtg_window u_win (.cnt(cnt_d), .cfg(sel_cfg), .hit(hit[p]));
  end

  assign vref_act = cfg_q[{1'b0, field_q}];
  assign vs_act   = cfg_q[{1'b1, field_q}];

  always_comb begin
    vref_d  = hit[0];
    vs_d    = hit[1];
    vflag_d = hit[0];
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      vref   <= 1'b0;
      vs     <= 1'b0;
      v_flag <= 1'b0;
    end else if (line_strobe) begin
      vref   <= vref_d;
      vs     <= vs_d;
      v_flag <= vflag_d;
    end
  end
endmodule

// File: rtl/vtg_checker.sv
module vtg_checker
  import vtg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              line_strobe,
  input logic              frame_start,
  input logic              field_id,
  input logic              field_q,
  input logic [LINE_W-1:0] cnt,
  input pulse_cfg_t        vref_cfg,
  input pulse_cfg_t        vs_cfg,
  input logic              vref,
  input logic              vs
);
  // R8
  hold_between_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_strobe |=> ($stable(vref) && $stable(vs)));

  // R2
  first_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_strobe && frame_start) |=> (cnt == LINE_W'(1)));

  // R2
  line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_strobe && !frame_start && (field_id == field_q) && (cnt != '1))
    |=> (cnt == $past(cnt) + 1'b1));

  // R6
  zero_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((vref_cfg.start == '0) || (vref_cfg.width == '0)) |-> !vref);

  // R3
  vref_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vref |-> ((cnt >= vref_cfg.start) &&
              ({1'b0, cnt} < {1'b0, vref_cfg.start} + {4'b0, vref_cfg.width})));

  // R4
  vs_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vs |-> ((cnt >= vs_cfg.start) &&
            ({1'b0, cnt} < {1'b0, vs_cfg.start} + {4'b0, vs_cfg.width})));
endmodule

bind vert_timing_gen vtg_checker i_vtg_checker (
  .clk(clk), .rst_n(rst_q_n), .line_strobe(line_strobe),
  .frame_start(frame_start), .field_id(field_id), .field_q(field_q),
  .cnt(cnt_q), .vref_cfg(vref_act), .vs_cfg(vs_act), .vref(vref), .vs(vs)
);

// File: tb/test_vert_timing_gen.sv
module test_vert_timing_gen;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, line_strobe = 1'b0, frame_start = 1'b0, field_id = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic vref, vs, v_flag;

  vert_timing_gen i_vert_timing_gen (
    .clk(clk), .rst_n(rst_n), .line_strobe(line_strobe), .frame_start(frame_start),
    .field_id(field_id), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .vref(vref), .vs(vs), .v_flag(v_flag)
  );

  int n_vec = 0, n_bad = 0;
  logic [2:0] exp_q[$];
  string      tag_q[$];
  logic [2:0] last_exp = 3'b000;
  string      cur_tag = "R9";
  logic       cap = 1'b0, mon_on = 1'b0;
  int m_lo[4], m_hi[4], m_w[4], s_start[4], s_w[4];
  int m_cnt = 0, m_fld = 0;

  task automatic check(string tag, logic [2:0] act, logic [2:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {vref,vs,v_flag} got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  always @(posedge clk) cap <= line_strobe;

  // monitor: pops expected items one cycle after each strobe, checks holds otherwise
  always @(negedge clk) begin
    if (mon_on) begin
      if (cap) begin
        if (exp_q.size() == 0) check("R8 unexpected update", {vref, vs, v_flag}, 3'bxxx);
        else begin
          logic [2:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, {vref, vs, v_flag}, e);
          last_exp = e;
        end
      end else check("R8 hold", {vref, vs, v_flag}, last_exp);
    end
  end

  function automatic bit in_win(int l, int s, int w);
    return (s != 0) && (w != 0) && (l >= s) && (l < s + w);
  endfunction

  task automatic wr(int a, int d);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = 8'(d);
    if (a < 12) begin
      int e, part;
      e = (a / 6) * 2 + (a % 6) / 3;
      part = a % 3;
      if (part == 0) m_lo[e] = d & 255;
      else if (part == 1) m_hi[e] = d & 7;
      else m_w[e] = d & 255;
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic setcfg(int p, int f, int start, int width);
    wr(p * 6 + f * 3, start & 255);
    wr(p * 6 + f * 3 + 1, start >> 8);
    wr(p * 6 + f * 3 + 2, width);
  endtask

  task automatic line(int f, bit fs, int gap);
    bit bnd, hr, hs;
    bnd = fs || (f != m_fld);
    if (bnd) begin
      for (int e = 0; e < 4; e++) begin
        s_start[e] = m_hi[e] * 256 + m_lo[e];
        s_w[e] = m_w[e];
      end
      m_cnt = 1;
      m_fld = f;
    end else if (m_cnt < 2047) m_cnt++;
    hr = in_win(m_cnt, s_start[f], s_w[f]);
    hs = in_win(m_cnt, s_start[2 + f], s_w[2 + f]);
    exp_q.push_back({hr, hs, hr});
    tag_q.push_back(cur_tag);
    line_strobe = 1'b1; field_id = f[0]; frame_start = fs;
    @(negedge clk);
    line_strobe = 1'b0; frame_start = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic field(int f, bit fs, int n);
    for (int i = 0; i < n; i++) line(f, fs && (i == 0), i % 3);
  endtask

  initial begin
    #(4 * 190000);
    n_vec++; n_bad++;
    $display("FAIL watchdog: got run still busy expected completion");
    finish_run();
  end

  initial begin
    for (int e = 0; e < 4; e++) begin
      m_lo[e] = 0; m_hi[e] = 0; m_w[e] = 0; s_start[e] = 0; s_w[e] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 reset", {vref, vs, v_flag}, 3'b000);
    mon_on = 1'b1;

    cur_tag = "R9 zero settings";
    field(0, 1, 4);
    field(1, 0, 4);

    // interlaced windows differing per field (R3, R4, R5)
    setcfg(0, 0, 3, 4); setcfg(1, 0, 1, 2);
    setcfg(0, 1, 5, 3); setcfg(1, 1, 2, 1);
    cur_tag = "R3/R4/R5 interlaced";
    for (int fr = 0; fr < 3; fr++) begin field(0, 1, 12); field(1, 0, 12); end

    // zero disables (R6)
    setcfg(0, 0, 3, 0); setcfg(1, 1, 0, 4);
    cur_tag = "R6 zero disable";
    for (int fr = 0; fr < 2; fr++) begin field(0, 1, 10); field(1, 0, 10); end

    // mid-field write deferred (R7)
    cur_tag = "R7 deferred write";
    field(0, 1, 3);
    setcfg(0, 0, 2, 5); setcfg(1, 1, 3, 2);
    field(0, 0, 8);
    field(1, 0, 8);
    field(0, 1, 8);

    // split layout with junk upper bits, ignored addresses (R1)
    wr(6, 4); wr(7, 8'hF9); wr(8, 3);
    for (int a = 12; a < 16; a++) wr(a, 8'hFF);
    cur_tag = "R1 layout";
    field(0, 1, 264);

    // saturation and 12-bit end (R2)
    setcfg(0, 0, 2040, 30);
    cur_tag = "R2 saturation";
    field(0, 1, 2060);

    // progressive (R10)
    setcfg(0, 1, 0, 0); setcfg(1, 1, 0, 0);
    setcfg(0, 0, 2, 3); setcfg(1, 0, 4, 2);
    cur_tag = "R10 progressive";
    for (int fr = 0; fr < 3; fr++) field(0, 1, 9);

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) check("R8 missing updates", 3'b000, 3'b111);
    finish_run();
  end
endmodule